// File: doc/BRIEF.md
# Bridge System Error Reporting Logic

This block sits in a two-port bus bridge and decides when the bridge drives its upstream (primary) system-error output low. It has two sources of events. The first is the system-error input from the downstream (secondary) bus. The second is a parity-error indication seen during a posted write that crosses the bridge.

Each source passes only through its own set of enable bits. These bits come from the command register and the bridge control register. The system-error enable in the command register gates every cause.

The block also keeps two sticky status flags:
- a signaled flag, set whenever the output is driven;
- a received flag, set whenever the downstream system-error input is seen.

Software clears either flag by pulsing a write-one-to-clear strobe. All inputs are sampled on the rising clock edge. The output and both flags are registered, so a cause sampled at one edge shows up on the output during the following clock.

Top module: `bridge_serr_report`

## Requirements
- R1: While `rst_n` is low at a rising edge, the edge drives `pri_serr_n` to 1 and clears both `sig_serr_sts` and `rcv_serr_sts`.
- R2: If `cmd_serr_en` was 0 at a sampling edge, `pri_serr_n` is 1 in the following cycle, whatever the other inputs were.
- R3: If `sec_serr_n` was 0, `bctl_serr_fwd` was 1 and `cmd_serr_en` was 1 at an edge, `pri_serr_n` is 0 in the following cycle.
- R4: A 0 sampled on `sec_serr_n` sets `rcv_serr_sts`, even when both enables are 0. With `bctl_serr_fwd` at 0, that input alone never drives `pri_serr_n` low.
- R5: In every cycle where `pri_serr_n` is 0, `sig_serr_sts` is 1.
- R6: The upstream parity case applies when `pw_valid` is 1 and `pw_upstream` is 1. In that case `pri_perr_n` at 0 is a cause and `sec_perr_n` is ignored. With `pw_valid` at 0, neither parity line is a cause.
- R7: The downstream parity case applies when `pw_valid` is 1 and `pw_upstream` is 0. In that case `sec_perr_n` at 0 is a cause and `pri_perr_n` is ignored.
- R8: A posted-write parity cause is dropped when `tgt_detected` is 1.
- R9: A posted-write parity cause needs both `cmd_perr_resp` and `bctl_perr_resp` at 1. If either is 0, the cause is dropped.
- R10: `pri_serr_n` is low for exactly one cycle per sampling edge that had a qualifying cause. It is 1 in the cycle after an edge with no cause.
- R11: A status flag that is 1 stays 1 while its clear strobe is 0.
- R12: A clear strobe (`clr_sig_serr` or `clr_rcv_serr`) sampled at 1 with no new event for that flag makes the flag 0 in the following cycle.
- R13: When a new event and the clear strobe for the same flag are sampled at the same edge, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_serr_n | input | 1 | System-error input from the downstream bus, active low |
| pri_perr_n | input | 1 | Parity-error line of the upstream bus, active low |
| sec_perr_n | input | 1 | Parity-error line of the downstream bus, active low |
| pw_valid | input | 1 | A posted write is in its data phase this cycle |
| pw_upstream | input | 1 | Direction of that posted write: 1 upstream, 0 downstream |
| tgt_detected | input | 1 | The bridge, acting as target, detected the parity error itself |
| cmd_serr_en | input | 1 | Command register: system-error enable |
| cmd_perr_resp | input | 1 | Command register: parity-error response |
| bctl_perr_resp | input | 1 | Bridge control register: parity-error response |
| bctl_serr_fwd | input | 1 | Bridge control register: downstream system-error forward enable |
| clr_sig_serr | input | 1 | Write-one-to-clear strobe for `sig_serr_sts` |
| clr_rcv_serr | input | 1 | Write-one-to-clear strobe for `rcv_serr_sts` |
| pri_serr_n | output | 1 | Upstream system-error output, active low, registered |
| sig_serr_sts | output | 1 | Sticky flag: the bridge has signaled a system error |
| rcv_serr_sts | output | 1 | Sticky flag: a downstream system error was received |

## Verification
The bench drives each parity line during a posted write in the wrong direction. A design that decodes the direction backwards would report errors that belong to the other bus, and would miss the real ones.

It clears a flag in the same cycle that a fresh event arrives. A design that lets the clear win would lose that event.

It holds a cause for several consecutive cycles and then removes it. This catches an output that stretches past the last cause, and an output that pulses only once for a run of causes.

It also sets each enable bit to 0 in turn, including only one of the two parity-response bits. It checks that the received flag still records downstream errors while forwarding is off.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  localparam int STS_W   = 2;
  localparam int STS_SIG = 0;
  localparam int STS_RCV = 1;

  typedef struct packed {
    logic serr_en;
    logic perr_resp;
  } cmd_ctl_t;

  typedef struct packed {
    logic serr_fwd;
    logic perr_resp;
  } bctl_t;

  typedef struct packed {
    logic valid;
    logic upstream;
    logic tgt_det;
  } pw_info_t;

  // Picks the parity line that belongs to the posted write's direction.
  // Returns 1 when that line is asserted (the lines are active low).
  function automatic logic dir_parity_hit(input logic upstream,
                                          input logic pri_line_n,
                                          input logic sec_line_n);
    return upstream ? ~pri_line_n : ~sec_line_n;
  endfunction

  // Sticky flag update: a fresh event dominates a same-cycle clear.
  function automatic logic sticky_next(input logic cur,
                                       input logic set_evt,
                                       input logic clr_req);
    return set_evt | (cur & ~clr_req);
  endfunction

endpackage

// File: rtl/bsr_cause.sv
module bsr_cause
  import bsr_pkg::*;
(
  input  logic     sec_serr_n,
  input  logic     pri_perr_n,
  input  logic     sec_perr_n,
  input  pw_info_t pw,
  input  cmd_ctl_t cmd,
  input  bctl_t    bctl,
  output logic     fwd_hit,
  output logic     pw_hit,
  output logic     rcv_evt,
  output logic     fire
);

  logic parity_seen;
  logic resp_ok;

  always_comb begin
    rcv_evt     = ~sec_serr_n;
    parity_seen = pw.valid & dir_parity_hit(pw.upstream, pri_perr_n, sec_perr_n);
    resp_ok     = cmd.perr_resp & bctl.perr_resp;
    pw_hit      = parity_seen & resp_ok & ~pw.tgt_det;
    fwd_hit     = rcv_evt & bctl.serr_fwd;
    fire        = cmd.serr_en & (fwd_hit | pw_hit);
  end

endmodule

// File: rtl/bsr_sticky.sv
module bsr_sticky #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_evt,
  input  logic [W-1:0] clr_req,
  output logic [W-1:0] sts
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) sts[i] <= 1'b0;
      else        sts[i] <= bsr_pkg::sticky_next(sts[i], set_evt[i], clr_req[i]);
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !clr_req[i]) |=> sts[i]);

    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[i] && !set_evt[i]) |=> !sts[i]);

    assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> sts[i]);
  end

endmodule

// File: rtl/bsr_pulse.sv
module bsr_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic serr_n
);

  always_ff @(posedge clk) begin
    if (!rst_n) serr_n <= 1'b1;
    else        serr_n <= ~fire;
  end

  assert_pulse_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !serr_n);

  assert_pulse_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> serr_n);

endmodule

// File: rtl/bridge_serr_report.sv
module bridge_serr_report
  import bsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sec_serr_n,
  input  logic pri_perr_n,
  input  logic sec_perr_n,
  input  logic pw_valid,
  input  logic pw_upstream,
  input  logic tgt_detected,
  input  logic cmd_serr_en,
  input  logic cmd_perr_resp,
  input  logic bctl_perr_resp,
  input  logic bctl_serr_fwd,
  input  logic clr_sig_serr,
  input  logic clr_rcv_serr,
  output logic pri_serr_n,
  output logic sig_serr_sts,
  output logic rcv_serr_sts
);

  cmd_ctl_t           cmd;
  bctl_t              bctl;
  pw_info_t           pw;
  logic               fwd_hit;
  logic               pw_hit;
  logic               rcv_evt;
  logic               fire;
  logic [STS_W-1:0]   sts_set;
  logic [STS_W-1:0]   sts_clr;
  logic [STS_W-1:0]   sts_q;

  always_comb begin
    cmd.serr_en    = cmd_serr_en;
    cmd.perr_resp  = cmd_perr_resp;
    bctl.serr_fwd  = bctl_serr_fwd;
    bctl.perr_resp = bctl_perr_resp;
    pw.valid       = pw_valid;
    pw.upstream    = pw_upstream;
    pw.tgt_det     = tgt_detected;
  end

  bsr_cause u_cause (
    .sec_serr_n (sec_serr_n),
    .pri_perr_n (pri_perr_n),
    .sec_perr_n (sec_perr_n),
    .pw         (pw),
    .cmd        (cmd),
    .bctl       (bctl),
    .fwd_hit    (fwd_hit),
    .pw_hit     (pw_hit),
    .rcv_evt    (rcv_evt),
    .fire       (fire)
  );

  always_comb begin
    sts_set          = '0;
    sts_clr          = '0;
    sts_set[STS_SIG] = fire;
    sts_set[STS_RCV] = rcv_evt;
    sts_clr[STS_SIG] = clr_sig_serr;
    sts_clr[STS_RCV] = clr_rcv_serr;
  end

  bsr_sticky #(.W(STS_W)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (sts_set),
    .clr_req (sts_clr),
    .sts     (sts_q)
  );

  bsr_pulse u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .serr_n (pri_serr_n)
  );

  assign sig_serr_sts = sts_q[STS_SIG];
  assign rcv_serr_sts = sts_q[STS_RCV];

  assert_master_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_serr_en |=> pri_serr_n);

  assert_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_serr_en && bctl_serr_fwd && !sec_serr_n) |=> !pri_serr_n);

  assert_rcv_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_serr_n |=> rcv_serr_sts);

  assert_sig_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_serr_n |-> sig_serr_sts);

  assert_upstream_pw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_serr_en && cmd_perr_resp && bctl_perr_resp && pw_valid && pw_upstream
     && !tgt_detected && !pri_perr_n) |=> !pri_serr_n);

  assert_downstream_pw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_serr_en && cmd_perr_resp && bctl_perr_resp && pw_valid && !pw_upstream
     && !tgt_detected && !sec_perr_n) |=> !pri_serr_n);

  assert_target_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_detected && (sec_serr_n || !bctl_serr_fwd)) |=> pri_serr_n);

  assert_resp_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cmd_perr_resp || !bctl_perr_resp) && (sec_serr_n || !bctl_serr_fwd))
    |=> pri_serr_n);

endmodule

// File: tb/bridge_serr_report_tb.sv
module bridge_serr_report_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_serr_n = 1'b1, pri_perr_n = 1'b1, sec_perr_n = 1'b1;
  logic pw_valid = 1'b0, pw_upstream = 1'b0, tgt_detected = 1'b0;
  logic cmd_serr_en = 1'b1, cmd_perr_resp = 1'b1;
  logic bctl_perr_resp = 1'b1, bctl_serr_fwd = 1'b1;
  logic clr_sig_serr = 1'b0, clr_rcv_serr = 1'b0;
  logic pri_serr_n, sig_serr_sts, rcv_serr_sts;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string phase    = "R1";

  // reference state
  logic m_out_n = 1'b1, m_sig = 1'b0, m_rcv = 1'b0;

  always #4 clk = ~clk;

  bridge_serr_report dut_i (
    .clk(clk), .rst_n(rst_n),
    .sec_serr_n(sec_serr_n), .pri_perr_n(pri_perr_n), .sec_perr_n(sec_perr_n),
    .pw_valid(pw_valid), .pw_upstream(pw_upstream), .tgt_detected(tgt_detected),
    .cmd_serr_en(cmd_serr_en), .cmd_perr_resp(cmd_perr_resp),
    .bctl_perr_resp(bctl_perr_resp), .bctl_serr_fwd(bctl_serr_fwd),
    .clr_sig_serr(clr_sig_serr), .clr_rcv_serr(clr_rcv_serr),
    .pri_serr_n(pri_serr_n), .sig_serr_sts(sig_serr_sts), .rcv_serr_sts(rcv_serr_sts)
  );

  // Behavioural model, evaluated from the requirement text.
  always @(posedge clk) begin
    bit report;
    bit parity;
    if (!rst_n) begin
      m_out_n = 1'b1; m_sig = 1'b0; m_rcv = 1'b0;
    end else begin
      parity = 0;
      if (pw_valid === 1'b1) begin
        if (pw_upstream) parity = (pri_perr_n == 1'b0);
        else             parity = (sec_perr_n == 1'b0);
      end
      if (tgt_detected || !(cmd_perr_resp && bctl_perr_resp)) parity = 0;
      report = 0;
      if (cmd_serr_en) begin
        if (bctl_serr_fwd && sec_serr_n == 1'b0) report = 1;
        if (parity) report = 1;
      end
      m_out_n = report ? 1'b0 : 1'b1;
      if (report) m_sig = 1'b1; else if (clr_sig_serr) m_sig = 1'b0;
      if (sec_serr_n == 1'b0) m_rcv = 1'b1; else if (clr_rcv_serr) m_rcv = 1'b0;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (!done) begin
      chk(phase, "pri_serr_n", pri_serr_n, m_out_n);
      chk(phase, "sig_serr_sts", sig_serr_sts, m_sig);
      chk(phase, "rcv_serr_sts", rcv_serr_sts, m_rcv);
    end
  end

  // Apply one cycle of stimulus, return at the negedge after the sampling edge.
  task automatic cyc(input logic s_serr, input logic p_perr, input logic s_perr,
                     input logic pwv, input logic up, input logic tgt,
                     input logic c_sig, input logic c_rcv);
    sec_serr_n = s_serr; pri_perr_n = p_perr; sec_perr_n = s_perr;
    pw_valid = pwv; pw_upstream = up; tgt_detected = tgt;
    clr_sig_serr = c_sig; clr_rcv_serr = c_rcv;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1, 1, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic clear_all();
    cyc(1, 1, 1, 0, 0, 0, 1, 1);
    idle();
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R1", "reset out", pri_serr_n, 1'b1);
    chk("R1", "reset sig", sig_serr_sts, 1'b0);
    chk("R1", "reset rcv", rcv_serr_sts, 1'b0);
    rst_n = 1'b1;
    idle();

    phase = "R3";
    cyc(0, 1, 1, 0, 0, 0, 0, 0);
    chk("R3", "forwarded out", pri_serr_n, 1'b0);
    chk("R4", "rcv set", rcv_serr_sts, 1'b1);
    chk("R5", "sig set", sig_serr_sts, 1'b1);
    idle();
    chk("R10", "out released", pri_serr_n, 1'b1);
    chk("R11", "sig held", sig_serr_sts, 1'b1);
    phase = "R12";
    cyc(1, 1, 1, 0, 0, 0, 1, 1);
    chk("R12", "sig cleared", sig_serr_sts, 1'b0);
    chk("R12", "rcv cleared", rcv_serr_sts, 1'b0);

    phase = "R2";
    cmd_serr_en = 1'b0;
    cyc(0, 0, 1, 1, 1, 0, 0, 0);
    chk("R2", "gated out", pri_serr_n, 1'b1);
    chk("R2", "gated sig", sig_serr_sts, 1'b0);
    chk("R4", "rcv with gate off", rcv_serr_sts, 1'b1);
    cmd_serr_en = 1'b1;
    clear_all();

    phase = "R4";
    bctl_serr_fwd = 1'b0;
    cyc(0, 1, 1, 0, 0, 0, 0, 0);
    chk("R4", "no forward", pri_serr_n, 1'b1);
    chk("R4", "rcv set fwd off", rcv_serr_sts, 1'b1);
    bctl_serr_fwd = 1'b1;
    clear_all();

    phase = "R6";
    cyc(1, 0, 1, 1, 1, 0, 0, 0);
    chk("R6", "upstream primary line", pri_serr_n, 1'b0);
    cyc(1, 1, 0, 1, 1, 0, 0, 0);
    chk("R6", "upstream secondary ignored", pri_serr_n, 1'b1);
    cyc(1, 0, 0, 0, 1, 0, 0, 0);
    chk("R6", "no posted write", pri_serr_n, 1'b1);

    phase = "R7";
    cyc(1, 1, 0, 1, 0, 0, 0, 0);
    chk("R7", "downstream secondary line", pri_serr_n, 1'b0);
    cyc(1, 0, 1, 1, 0, 0, 0, 0);
    chk("R7", "downstream primary ignored", pri_serr_n, 1'b1);

    phase = "R8";
    clear_all();
    cyc(1, 1, 0, 1, 0, 1, 0, 0);
    chk("R8", "target detected", pri_serr_n, 1'b1);
    chk("R8", "sig untouched", sig_serr_sts, 1'b0);

    phase = "R9";
    cmd_perr_resp = 1'b0;
    cyc(1, 0, 1, 1, 1, 0, 0, 0);
    chk("R9", "cmd resp off", pri_serr_n, 1'b1);
    cmd_perr_resp = 1'b1; bctl_perr_resp = 1'b0;
    cyc(1, 1, 0, 1, 0, 0, 0, 0);
    chk("R9", "bctl resp off", pri_serr_n, 1'b1);
    bctl_perr_resp = 1'b1;

    phase = "R10";
    for (int k = 0; k < 3; k++) begin
      cyc(1, 1, 0, 1, 0, 0, 0, 0);
      chk("R10", "run low", pri_serr_n, 1'b0);
    end
    idle();
    chk("R10", "run ends", pri_serr_n, 1'b1);

    phase = "R13";
    cyc(0, 1, 1, 0, 0, 0, 1, 1);
    chk("R13", "sig survives clear", sig_serr_sts, 1'b1);
    chk("R13", "rcv survives clear", rcv_serr_sts, 1'b1);
    clear_all();

    phase = "random R10";
    for (int n = 0; n < 3000; n++) begin
      cmd_serr_en    = ($urandom_range(0, 7) != 0);
      cmd_perr_resp  = ($urandom_range(0, 5) != 0);
      bctl_perr_resp = ($urandom_range(0, 5) != 0);
      bctl_serr_fwd  = ($urandom_range(0, 3) != 0);
      if (n % 500 == 250) begin rst_n = 1'b0; phase = "random R1"; end
      else begin rst_n = 1'b1; phase = "random R10"; end
      cyc($urandom_range(0, 5) != 0, $urandom_range(0, 3) != 0,
          $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
          $urandom_range(0, 1) == 1, $urandom_range(0, 4) == 0,
          $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

endmodule